// File: doc/BRIEF.md
# Multidrop UART Receiver Address Filter

This block is the receive half of a serial port that sits as one of several listeners on a shared line. It finds start bits with 16x oversampling, shifts in 5 to 8 data bits LSB first, and takes the next bit on the wire as a frame-type flag. A type value of one marks an address frame and zero marks a data frame. For the 9-bit character code the type flag is the ninth data bit. For shorter characters it sits where the first stop bit would be, so the sender must use two stop bits.

When the filter control is set, data frames are thrown away before they reach the buffer, and only address frames raise receive-complete. Software reads the address from the data register and compares it with its own identity. If they match, it clears the filter so that the data frames that follow are accepted. Once the last data frame has arrived, it sets the filter again. The data address is shared: reads return the received byte and writes load a transmit holding byte for a neighbouring transmitter. The control address is laid out so that the filter bit can be written without clearing the write-one-to-clear dropped-frame flag.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After reset, receive-complete, framing error, the filter bit and the dropped flag are all 0, and `tx_data` is 0. The receiver does not look for a start bit until it has seen the line high, so a line held low through and after reset produces no frame.
- R2: A start bit counts only when the majority of the samples at oversample ticks 7, 8 and 9 of the start bit are low. A low pulse of 4 ticks produces no frame.
- R3: Character-size codes 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Codes 4, 5 and 6 give 8 data bits. Code 7 is the 9-bit size: 8 data bits followed by a ninth bit. Bits arrive LSB first, and the byte is right-aligned with its unused upper bits 0.
- R4: The bit that follows the last data bit is the frame type: 1 for an address frame, 0 for a data frame. It appears on `rx_bit9` and at control bit 3, together with its byte.
- R5: While the filter bit is 1, a frame with type 0 leaves `rx_byte`, `rx_bit9`, `rx_done` and `frame_err` unchanged and sets the dropped flag (control bit 4).
- R6: While the filter bit is 1, a frame with type 1 is stored and raises `rx_done`.
- R7: While the filter bit is 0, every frame is stored and raises `rx_done`, whatever its type.
- R8: A low sample of the bit after the type bit sets `frame_err` for that stored frame, and a high sample clears it. A dropped frame does not change `frame_err`. After a framing error the receiver waits for the line to go high again.
- R9: A read of address 0 returns `rx_byte` and clears `rx_done` at the next clock edge. A frame accepted in that same cycle wins. A write to address 0 loads `tx_data` and leaves the receive state alone.
- R10: A write to address 1 loads the filter bit from data bit 0. Writing 1 to data bit 4 clears the dropped flag, and writing 0 there leaves it alone. A read of address 1 returns {000, dropped, ninth bit, framing error, receive-complete, filter} from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| char_size | input | 3 | Character-size code (0..3 give 5..8 bits, 7 gives 9 bits) |
| reg_addr | input | 1 | Register address: 0 data, 1 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| rx_byte | output | 8 | Last stored received byte |
| rx_bit9 | output | 1 | Frame-type bit of the stored frame |
| rx_done | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Framing error of the stored frame |
| tx_data | output | 8 | Transmit holding byte written through address 0 |

## Verification
A frame's result is decided at the middle sample of the bit after the type bit. It reaches the outputs one clock later, so the bench holds the line high for two further bit times before it enables comparison with its reference model. A read clears `rx_done` at the edge that ends the read cycle, and a register write updates state at that same edge. The bench therefore samples the read data within the read cycle and makes its model changes only after that edge. Outside frame reception, the model is compared with the outputs on every clock, 2 ns after the falling edge.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int MAX_DATA = 8;

  // Control register bit positions (software decodes these)
  localparam int CTL_FILT = 0;
  localparam int CTL_DONE = 1;
  localparam int CTL_FERR = 2;
  localparam int CTL_B9   = 3;
  localparam int CTL_DROP = 4;

  typedef enum logic [2:0] {
    RX_HOLD, RX_IDLE, RX_START, RX_DATA, RX_TYPE, RX_STOP
  } rx_state_t;

  // Codes 0..3 give 5..8 data bits; 4..7 give 8 (code 7 adds the ninth bit,
  // which is the type bit taken after the data in every mode).
  function automatic logic [3:0] data_bits(input logic [2:0] code);
    if (code <= 3'd3) return 4'd5 + {2'b00, code[1:0]};
    else return 4'd8;
  endfunction
endpackage

// File: rtl/mdrop_sync.sv
module mdrop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdrop_rx_fsm.sv
module mdrop_rx_fsm
  import mdrop_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rxs,
  input  logic [2:0]          char_size,
  output logic                frm_valid,
  output logic [MAX_DATA-1:0] frm_data,
  output logic                frm_type,
  output logic                frm_stop
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] S_A  = CW'(MID - 1);
  localparam logic [CW-1:0] S_B  = CW'(MID);
  localparam logic [CW-1:0] S_V  = CW'(MID + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_t           st_q, st_n;
  logic [CW-1:0]       cnt_q, cnt_n;
  logic [2:0]          idx_q, idx_n;
  logic [3:0]          nb_q, nb_n;
  logic [MAX_DATA-1:0] sh_q, sh_n;
  logic                sa_q, sa_n, sb_q, sb_n;
  logic                typ_q, typ_n, stp_q, stp_n, vld_q, vld_n;
  logic                vote;

  assign vote = (sa_q & sb_q) | (sa_q & rxs) | (sb_q & rxs);

  always_comb begin
    st_n = st_q;  cnt_n = cnt_q; idx_n = idx_q; nb_n = nb_q;
    sh_n = sh_q;  sa_n = sa_q;   sb_n = sb_q;
    typ_n = typ_q; stp_n = stp_q; vld_n = 1'b0;
    if (tick) begin
      case (st_q)
        RX_HOLD: if (rxs) st_n = RX_IDLE;
        RX_IDLE: if (!rxs) begin
          st_n  = RX_START;
          cnt_n = '0;
          nb_n  = data_bits(char_size);
        end
        default: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == S_A) sa_n = rxs;
          if (cnt_q == S_B) sb_n = rxs;
          if (cnt_q == S_V) begin
            case (st_q)
              RX_START: if (vote) st_n = RX_IDLE;
              RX_DATA:  sh_n = {vote, sh_q[MAX_DATA-1:1]};
              RX_TYPE:  typ_n = vote;
              RX_STOP: begin
                vld_n = 1'b1;
                stp_n = vote;
                st_n  = vote ? RX_IDLE : RX_HOLD;
              end
              default: ;
            endcase
          end
          if (cnt_q == LAST) begin
            cnt_n = '0;
            case (st_q)
              RX_START: begin st_n = RX_DATA; idx_n = '0; end
              RX_DATA:
                if ({1'b0, idx_q} == nb_q - 4'd1) st_n = RX_TYPE;
                else idx_n = idx_q + 1'b1;
              RX_TYPE: st_n = RX_STOP;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_HOLD; cnt_q <= '0; idx_q <= '0; nb_q <= 4'd8;
      sh_q <= '0; sa_q <= 1'b1; sb_q <= 1'b1;
      typ_q <= 1'b0; stp_q <= 1'b1; vld_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; idx_q <= idx_n; nb_q <= nb_n;
      sh_q <= sh_n; sa_q <= sa_n; sb_q <= sb_n;
      typ_q <= typ_n; stp_q <= stp_n; vld_q <= vld_n;
    end
  end

  assign frm_valid = vld_q;
  assign frm_data  = sh_q >> (4'd8 - nb_q);
  assign frm_type  = typ_q;
  assign frm_stop  = stp_q;
endmodule

// File: rtl/mdrop_rx_regs.sv
module mdrop_rx_regs
  import mdrop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_valid,
  input  logic [MAX_DATA-1:0] frm_data,
  input  logic                frm_type,
  input  logic                frm_stop,
  input  logic                reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic [7:0]          rx_byte,
  output logic                rx_bit9,
  output logic                rx_done,
  output logic                frame_err,
  output logic                filter_en,
  output logic                drop_seen,
  output logic [7:0]          tx_data
);
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  logic       accept, drop, rd_data, wr_data, wr_ctrl;
  logic [7:0] byte_n, tx_n, ctrl_v;
  logic       b9_n, done_n, ferr_n, filt_n, drop_n;

  assign accept  = frm_valid & (~filter_en | frm_type);
  assign drop    = frm_valid & filter_en & ~frm_type;
  assign rd_data = reg_rd & (reg_addr == ADDR_DATA);
  assign wr_data = reg_wr & (reg_addr == ADDR_DATA);
  assign wr_ctrl = reg_wr & (reg_addr == ADDR_CTRL);

  always_comb begin
    byte_n = rx_byte; b9_n = rx_bit9; ferr_n = frame_err;
    done_n = rx_done; filt_n = filter_en; drop_n = drop_seen; tx_n = tx_data;
    if (accept) begin
      byte_n = frm_data; b9_n = frm_type; ferr_n = ~frm_stop; done_n = 1'b1;
    end else if (rd_data) begin
      done_n = 1'b0;
    end
    if (drop) drop_n = 1'b1;
    else if (wr_ctrl && reg_wdata[CTL_DROP]) drop_n = 1'b0;
    if (wr_ctrl) filt_n = reg_wdata[CTL_FILT];
    if (wr_data) tx_n = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0; rx_bit9 <= 1'b0; frame_err <= 1'b0; rx_done <= 1'b0;
      filter_en <= 1'b0; drop_seen <= 1'b0; tx_data <= '0;
    end else begin
      rx_byte <= byte_n; rx_bit9 <= b9_n; frame_err <= ferr_n; rx_done <= done_n;
      filter_en <= filt_n; drop_seen <= drop_n; tx_data <= tx_n;
    end
  end

  always_comb begin
    ctrl_v = '0;
    ctrl_v[CTL_FILT] = filter_en;
    ctrl_v[CTL_DONE] = rx_done;
    ctrl_v[CTL_FERR] = frame_err;
    ctrl_v[CTL_B9]   = rx_bit9;
    ctrl_v[CTL_DROP] = drop_seen;
  end

  assign reg_rdata = (reg_addr == ADDR_CTRL) ? ctrl_v : rx_byte;
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrop_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       baud_tick,
  input  logic [2:0] char_size,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [7:0] rx_byte,
  output logic       rx_bit9,
  output logic       rx_done,
  output logic       frame_err,
  output logic [7:0] tx_data
);
  logic                rst_sn, rxs;
  logic                frm_valid, frm_type, frm_stop;
  logic [MAX_DATA-1:0] frm_data;
  logic                filter_en, drop_seen;

  mdrop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn));

  // Line reads low until synchronised, so the idle-high wait holds off reception
  mdrop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rx_sync (
    .clk(clk), .rst_n(rst_sn), .d(rx_line), .q(rxs));

  mdrop_rx_fsm #(.OSR(OSR)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .tick(baud_tick), .rxs(rxs),
    .char_size(char_size), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_type(frm_type), .frm_stop(frm_stop));

  mdrop_rx_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_type(frm_type), .frm_stop(frm_stop), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .rx_done(rx_done), .frame_err(frame_err), .filter_en(filter_en),
    .drop_seen(drop_seen), .tx_data(tx_data));
endmodule

// File: rtl/mdrop_uart_rx_chk.sv
module mdrop_uart_rx_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic       frm_valid,
  input logic       frm_type,
  input logic       frm_stop,
  input logic       filter_en,
  input logic       drop_seen,
  input logic [7:0] rx_byte,
  input logic       rx_bit9,
  input logic       rx_done,
  input logic       frame_err
);
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_rd && !reg_addr && !frm_valid) |=> !rx_done);

  // R5
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (frm_valid && filter_en && !frm_type && !reg_rd) |=>
      ($stable(rx_byte) && $stable(rx_done) && $stable(frame_err) &&
       $stable(rx_bit9) && drop_seen));

  // R6
  addr_take_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (frm_valid && frm_type) |=> (rx_done && rx_bit9));

  // R7
  open_take_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (frm_valid && !filter_en) |=> rx_done);

  // R8
  ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (frm_valid && !frm_stop && (!filter_en || frm_type)) |=> frame_err);

  // R10
  filt_wr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr) |=> (filter_en == $past(reg_wdata[0])));

  // R10
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_wr && reg_addr && !reg_wdata[4] && !frm_valid) |=> $stable(drop_seen));
endmodule

bind mdrop_uart_rx mdrop_uart_rx_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .frm_valid(frm_valid),
  .frm_type(frm_type), .frm_stop(frm_stop), .filter_en(filter_en),
  .drop_seen(drop_seen), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
  .rx_done(rx_done), .frame_err(frame_err));

// File: tb/mdrop_uart_rx_tb.sv
`timescale 1ns/1ps
module mdrop_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n, rx_line, baud_tick, reg_addr, reg_wr, reg_rd;
  logic [2:0] char_size;
  logic [7:0] reg_wdata, reg_rdata, rx_byte, tx_data;
  logic       rx_bit9, rx_done, frame_err;

  int checks = 0, errors = 0;
  bit finished = 0, cmp_en = 0;
  string cur_req = "R1";

  // reference model state
  logic [7:0] m_byte = 0, m_tx = 0;
  logic m_b9 = 0, m_done = 0, m_ferr = 0, m_filt = 0, m_drop = 0;

  always #5 clk = ~clk;

  mdrop_uart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
    .char_size(char_size), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_done(rx_done),
    .frame_err(frame_err), .tx_data(tx_data));

  initial baud_tick = 1'b0;
  always @(negedge clk) baud_tick = ~baud_tick;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison with the model outside frame reception
  always @(negedge clk) begin
    #2;
    if (cmp_en && !finished)
      chk(cur_req, {rx_byte, rx_bit9, rx_done, frame_err, tx_data},
                   {m_byte, m_b9, m_done, m_ferr, m_tx});
  end

  function automatic int nbits(input int code);
    return (code < 4) ? code + 5 : 8;
  endfunction

  task automatic drive_bit(input logic v);
    rx_line = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input int code, input logic [7:0] d, input logic t,
                      input logic stp);
    int n = nbits(code);
    cmp_en = 0;
    char_size = 3'(code);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i]);
    drive_bit(t);
    drive_bit(stp);
    drive_bit(1'b1);
    drive_bit(1'b1);
    if (!m_filt || t) begin
      m_byte = d & 8'((1 << n) - 1);
      m_b9 = t; m_ferr = !stp; m_done = 1;
    end else m_drop = 1;
    cmp_en = 1;
  endtask

  task automatic rd(input logic a, input string req);
    logic [7:0] got, exp;
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 got = reg_rdata;
    exp = a ? {3'b000, m_drop, m_b9, m_ferr, m_done, m_filt} : m_byte;
    chk(req, got, exp);
    @(negedge clk);
    reg_rd = 0;
    if (!a) m_done = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    if (a) begin
      m_filt = v[0];
      if (v[4]) m_drop = 0;
    end else m_tx = v;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 0; rx_line = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0;
    reg_wdata = 0; char_size = 3'd3;
    repeat (5) @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    // R1: line low after reset must not start a frame
    repeat (400) @(negedge clk);
    rx_line = 1;
    repeat (100) @(negedge clk);
    chk("R1", rx_done, 0);
    rd(1, "R1");

    // R7 R3 R4: filter off, 8 bits
    cur_req = "R7";
    send(3, 8'hA5, 0, 1);
    chk("R3", rx_byte, 8'hA5);
    rd(0, "R9");
    chk("R9", rx_done, 0);

    cur_req = "R3";
    send(0, 8'h15, 1, 1);
    chk("R4", rx_bit9, 1);
    rd(1, "R4");
    send(2, 8'hDA, 0, 1);
    chk("R3", rx_byte, 8'h5A);
    send(7, 8'h3C, 1, 1);
    chk("R4", {rx_bit9, rx_byte}, 9'h13C);
    send(5, 8'hC3, 0, 1);
    chk("R3", rx_byte, 8'hC3);
    rd(0, "R9");

    // R10 filter on, R5 drop
    cur_req = "R5";
    wr(1, 8'h01);
    rd(1, "R10");
    send(3, 8'h77, 0, 1);
    chk("R5", {rx_done, rx_byte}, {1'b0, 8'hC3});
    rd(1, "R5");
    // R8: dropped frame with bad stop leaves frame_err alone
    cur_req = "R8";
    send(3, 8'h66, 0, 0);
    chk("R8", frame_err, 0);
    // R6 address frame accepted
    cur_req = "R6";
    send(7, 8'h42, 1, 1);
    chk("R6", {rx_done, rx_bit9}, 2'b11);
    rd(0, "R6");

    // R10 write bit4=0 keeps drop flag, clears filter
    cur_req = "R10";
    wr(1, 8'h00);
    rd(1, "R10");
    cur_req = "R7";
    send(3, 8'h99, 0, 1);
    chk("R7", {rx_done, rx_byte}, {1'b1, 8'h99});
    wr(1, 8'h10);
    rd(1, "R10");

    // R8 framing error stored, then cleared by a good frame
    cur_req = "R8";
    send(3, 8'h11, 1, 0);
    chk("R8", frame_err, 1);
    send(3, 8'h22, 0, 1);
    chk("R8", {frame_err, rx_byte}, {1'b0, 8'h22});
    rd(0, "R9");

    // R2 short low glitch
    cur_req = "R2";
    cmp_en = 0;
    rx_line = 0;
    repeat (8) @(negedge clk);
    rx_line = 1;
    repeat (600) @(negedge clk);
    cmp_en = 1;
    @(negedge clk);
    chk("R2", rx_done, 0);

    // R9 transmit write leaves receive data
    cur_req = "R9";
    wr(0, 8'h6E);
    chk("R9", {tx_data, rx_byte}, {8'h6E, 8'h22});
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule